// File: doc/BRIEF.md
# Four-Lane 7:1 Frame Deserializer

This block takes four serial data lanes and a forwarded frame clock, all sampled on one bit clock that runs at seven times the frame rate. Each lane carries seven bits per frame. The frame clock is high for four bit slots and then low for three. The block keeps a history of the last seven frame-clock samples and uses it to find where each frame begins. The first slot of a frame is the first slot in which the frame clock is high.

When a full frame has been shifted in, the 28 lane bits are rearranged into a parallel word. This uses a fixed, non-contiguous lane/slot-to-bit map. The word is presented together with a one-cycle strobe, once per frame. No word is released until three consecutive well-spaced frames have been seen. An active-low sleep input clears every register and keeps the block silent. After sleep is released, lock must be earned again before any word is released.

Top module: `lvds_frame_rx`

## Requirements
- R1: Lane 0's seven slots, first to last, map to output bits 7, 6, 4, 3, 2, 1, 0.
- R2: Lane 1's slots, first to last, map to bits 18, 15, 14, 13, 12, 9, 8. Lane 2's slots map to bits 26, 25, 24, 22, 21, 20, 19.
- R3: Lane 3's slots, first to last, map to bits 23, 17, 16, 11, 10, 5, 27.
- R4: A frame is the seven slots whose frame-clock samples are 1,1,1,1,0,0,0 in arrival order. Slot 0 is the first high sample. Alignment is found for any starting phase of the stream.
- R5: `word_stb` is high for exactly one cycle. It is high in the cycle after the edge that samples a frame's seventh slot. `word_out` changes only with the strobe and holds otherwise.
- R6: `locked` rises on the edge after the third consecutive frame spaced seven slots apart. The first word released is the fourth frame. Frames before that produce no strobe.
- R7: A frame boundary that is missing seven slots after the previous one drops `locked` on that edge. No strobe appears until three good frames have relocked the block. The first word after relock is from the frame following those three.
- R8: While `sleep_n` is low, `word_out`, `word_stb` and `locked` are zero from the next edge on. Any frames driven during that time are ignored.
- R9: After `sleep_n` is released, the block behaves as from reset: it locks on three frames and then releases the next one.
- R10: While `rst_n` is low (asynchronous), all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, seven times the frame rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_n | input | 1 | Active-low shutdown and synchronous clear |
| fclk_in | input | 1 | Sampled forwarded frame clock |
| lane_in | input | 4 | One serial bit per lane per slot |
| word_out | output | 28 | Reassembled parallel word |
| word_stb | output | 1 | One-cycle pulse marking a new word |
| locked | output | 1 | Frame alignment established |

## Verification
Number the sampling edges from the first slot of a run, with a phase offset of k slots. Frame f then ends on the edge that samples slot k+7f+6. Its strobe and word appear one edge later, at edge k+7f+7. `locked` also changes at that edge: after frame 2, or when a frame boundary is missing. A sleep request takes effect one edge after it is sampled.

The bench drives inputs and samples outputs on falling edges. After each rising edge it computes the expected strobe, lock and word from the edge index alone. The offset is swept over all seven phases, and runs with a broken frame cover the relock timing.

// File: rtl/lvds_frame_rx.sv
module lvds_frame_rx #(
  parameter int LOCK_FRAMES = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sleep_n,
  input  logic        fclk_in,
  input  logic [3:0]  lane_in,
  output logic [27:0] word_out,
  output logic        word_stb,
  output logic        locked
);
  localparam int LANES = 4;
  localparam int SLOTS = 7;
  localparam int WIDTH = LANES * SLOTS;
  localparam int HW    = $clog2(LOCK_FRAMES + 1);
  localparam logic [SLOTS-1:0] SHAPE = 7'b1111000;
  localparam logic [2:0] GAP_MAX = 3'd7;

  function automatic int out_bit(input int l, input int s);
    case (l * SLOTS + s)
      0: return 7;   1: return 6;   2: return 4;   3: return 3;
      4: return 2;   5: return 1;   6: return 0;
      7: return 18;  8: return 15;  9: return 14;  10: return 13;
      11: return 12; 12: return 9;  13: return 8;
      14: return 26; 15: return 25; 16: return 24; 17: return 22;
      18: return 21; 19: return 20; 20: return 19;
      21: return 23; 22: return 17; 23: return 16; 24: return 11;
      25: return 10; 26: return 5;  default: return 27;
    endcase
  endfunction

  logic [SLOTS-1:0] shreg [LANES];
  logic [SLOTS-1:0] fhist;
  logic [2:0]       gap;
  logic [HW-1:0]    hits;
  logic [WIDTH-1:0] mapped;

  wire boundary = (fhist == SHAPE);
  wire spaced   = (gap == 3'd6);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      localparam int OB = out_bit(l, s);
      assign mapped[OB] = shreg[l][SLOTS-1-s];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || !sleep_n) begin
      for (int i = 0; i < LANES; i++) shreg[i] <= '0;
      fhist    <= '0;
      gap      <= GAP_MAX;
      hits     <= '0;
      locked   <= 1'b0;
      word_out <= '0;
      word_stb <= 1'b0;
    end else begin
      for (int i = 0; i < LANES; i++) shreg[i] <= {shreg[i][SLOTS-2:0], lane_in[i]};
      fhist    <= {fhist[SLOTS-2:0], fclk_in};
      word_stb <= boundary && locked;
      if (boundary && locked) word_out <= mapped;
      if (boundary) begin
        gap <= '0;
        if (spaced && hits != '0) begin
          if (hits != HW'(LOCK_FRAMES)) hits <= hits + 1'b1;
          if (int'(hits) >= LOCK_FRAMES - 1) locked <= 1'b1;
        end else begin
          hits   <= HW'(1);
          locked <= (LOCK_FRAMES == 1);
        end
      end else begin
        if (gap != GAP_MAX) gap <= gap + 1'b1;
        if (spaced) begin
          hits   <= '0;
          locked <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/lvds_frame_rx_chk.sv
module lvds_frame_rx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sleep_n,
  input logic [27:0] word_out,
  input logic        word_stb,
  input logic        locked
);
  // R5
  stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb |=> !word_stb);
  // R5
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sleep_n) && !word_stb) |-> $stable(word_out));
  // R6
  stb_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb |-> locked);
  // R6
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> !word_stb);
  // R8
  sleep_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_n |=> (word_out == '0 && !word_stb && !locked));
endmodule

bind lvds_frame_rx lvds_frame_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n),
  .word_out(word_out), .word_stb(word_stb), .locked(locked)
);

// File: tb/lvds_frame_rx_test.sv
`timescale 1ns/1ps
module lvds_frame_rx_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_n = 1'b1;
  logic fclk_in = 1'b0;
  logic [3:0] lane_in = '0;
  logic [27:0] word_out;
  logic word_stb;
  logic locked;

  int total = 0;
  int bad = 0;
  logic [31:0] seed = 32'h1234_5678;
  logic [27:0] words [16];

  // R1, R2, R3: output bit for lane l, slot s at index l*7+s
  int lane_map [28] = '{7, 6, 4, 3, 2, 1, 0,
                        18, 15, 14, 13, 12, 9, 8,
                        26, 25, 24, 22, 21, 20, 19,
                        23, 17, 16, 11, 10, 5, 27};

  always #2 clk = ~clk;

  lvds_frame_rx uut (
    .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .fclk_in(fclk_in),
    .lane_in(lane_in), .word_out(word_out), .word_stb(word_stb), .locked(locked)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit lock_after(input int f, input int b);
    return (f >= 2 && (b < 0 || f < b)) || (b >= 0 && f >= b + 3);
  endfunction

  function automatic bit emits(input int f, input int b);
    return f >= 1 && lock_after(f - 1, b) && f != b;
  endfunction

  task automatic drive_frame_slot(input int f, input int s, input bit corrupt);
    fclk_in = corrupt ? 1'b1 : (s < 4);
    for (int l = 0; l < 4; l++) lane_in[l] = words[f][lane_map[l*7+s]];
  endtask

  // R4 phase offset k, R6 lock, R7 break at frame b (b<0: none)
  task automatic run(input int k, input int nf, input int b);
    for (int i = 0; i < nf; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      words[i] = seed[31:4];
    end
    for (int n = 0; n <= k + 7*nf + 1; n++) begin
      @(negedge clk);
      if (n > 0) begin
        int m = n - 1;
        int r = m - k;
        int f = (r >= 7) ? (r - 7) / 7 : -1;
        bit lk = (f >= 0) && lock_after(f, b);
        bit st = (r >= 7) && ((r % 7) == 0) && (f < nf) && emits(f, b);
        chk("R5 R6 R7 strobe", {31'd0, word_stb}, {31'd0, st});
        chk("R6 R7 lock", {31'd0, locked}, {31'd0, lk});
        if (st) chk("R1 R2 R3 R4 word", {4'd0, word_out}, {4'd0, words[f]});
      end
      if (n < k) begin
        fclk_in = ((7 - k + n) < 4);
        lane_in = 4'hA;
      end else if (n <= k + 7*nf) begin
        if ((n - k) / 7 < nf) drive_frame_slot((n - k) / 7, (n - k) % 7, ((n - k) / 7) == b);
        else begin
          fclk_in = 1'b1;
          lane_in = '0;
        end
      end
    end
  endtask

  // R8: frames driven during sleep are ignored and everything stays clear
  task automatic sleep_phase();
    for (int i = 0; i < 28; i++) begin
      @(negedge clk);
      if (i > 0) begin
        chk("R8 sleep strobe", {31'd0, word_stb}, 32'd0);
        chk("R8 sleep lock", {31'd0, locked}, 32'd0);
        chk("R8 sleep word", {4'd0, word_out}, 32'd0);
      end
      sleep_n = 1'b0;
      drive_frame_slot(i / 7, i % 7, 1'b0);
    end
    @(negedge clk);
    chk("R8 sleep word", {4'd0, word_out}, 32'd0);
    fclk_in = 1'b0;
    lane_in = '0;
    sleep_n = 1'b1;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) words[i] = '0;
    repeat (3) @(negedge clk);
    chk("R10 reset word", {4'd0, word_out}, 32'd0);
    chk("R10 reset strobe", {31'd0, word_stb}, 32'd0);
    chk("R10 reset lock", {31'd0, locked}, 32'd0);
    rst_n = 1'b1;
    // R4 sweep every phase; R9 each run after the first follows a sleep
    for (int k = 0; k < 7; k++) begin
      run(k, 10, -1);
      sleep_phase();
    end
    // R7 broken frame mid-stream, then relock
    run(2, 14, 5);
    sleep_phase();
    run(5, 13, 3);
    sleep_phase();
    // R9 release and relock from zero phase
    run(0, 6, -1);
    $display("%0d/%0d checks passed", total - bad, total);
    $finish;
  end

  initial begin
    #(400000);
    total++;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - bad, total);
    $finish;
  end
endmodule